// File: doc/BRIEF.md
# Software Reset Controller

This block produces the internal reset outputs of a two-core I/O processor from software and watchdog requests. The watchdog counter and the register file live elsewhere and reach it as pulses and level bits. A write to the coordinated-reset bit or a watchdog expiry starts a peripheral-bus reset. This reset is stretched to a fixed minimum length. It leaves the configuration-space registers alone, because those follow a separate output that only the fundamental reset drives. Each core has its own reset. A core is held in reset indefinitely while its hold bit is set. A targeted request from one core gives any core a fixed-length reset pulse, and the requester may name itself as the target.

The peripheral-bus sequencer has two states. In `BUS_IDLE` a request takes the transition *start* to `BUS_PULSE`. `BUS_PULSE` counts `BUS_MIN` cycles, absorbs any further request, and takes *finish* back to `BUS_IDLE`. Each core sequencer has three states:
- `CORE_RUN` goes to `CORE_HELD` on *hold* and to `CORE_PULSE` on *hit*.
- `CORE_PULSE` goes to `CORE_HELD` on *hold* and back to `CORE_RUN` on *expire* after `CORE_MIN` cycles.
- `CORE_HELD` goes back to `CORE_RUN` on *release* once the hold bit clears.

Each core sequencer is cleared only by the fundamental reset. A self-targeted pulse therefore runs to its end while the requesting core sits in reset. Strap values are latched once, when the fundamental reset ends. No software reset re-samples them.

Top module: `swrst_ctrl`

## Requirements
- R1: While `rst_n` is low, `cfg_rst_o`, `bus_rst_o` and every `core_rst_o` bit are 1 and `strap_lock_o` is 0. After the first rising clock edge that sees `rst_n` high, those resets are 0 and `strap_lock_o` is 1.
- R2: A one-cycle pulse on `coord_wr` or on `wdt_expire` sets `bus_rst_o` from the next clock edge. It then stays 1 for exactly `BUS_MIN` (default 16) cycles.
- R3: Requests that arrive together, or while a bus pulse is running (including its last cycle), merge into that pulse. The pulse stays exactly `BUS_MIN` cycles long and no second pulse follows.
- R4: `cfg_rst_o` stays 0 during every software-initiated reset, both bus and core.
- R5: `strap_q_o` takes the value of `strap_in` at the first clock edge after `rst_n` rises. It then stays unchanged and `strap_lock_o` stays 1 through every software reset, whatever `strap_in` does.
- R6: While `hold_core[i]` is 1, `core_rst_o[i]` is 1 from the next clock edge onward. It returns to 0 one edge after the bit clears.
- R7: A `tgt_req` pulse is valid when `tgt_src < NCORE`, `tgt_dst < NCORE`, and the source core is not in reset. Such a pulse sets `core_rst_o[tgt_dst]` from the next edge for exactly `CORE_MIN` (default 8) cycles.
- R8: A request with `tgt_src == tgt_dst` resets the requester itself. The full `CORE_MIN`-cycle pulse still completes.
- R9: A targeted request is ignored and no core reset changes in either of these cases: the source core is in reset, or either ID is `NCORE` or above.
- R10: A bus reset does not assert any `core_rst_o`, and a core reset does not assert `bus_rst_o`.
- R11: A hold bit set during a targeted pulse takes priority. The core stays in reset past the pulse length until the bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Fundamental reset, active low, asynchronous |
| coord_wr | input | 1 | Write pulse to the coordinated-reset bit |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| hold_core | input | NCORE | Per-core hold-in-reset register bits |
| tgt_req | input | 1 | Targeted core-reset request pulse |
| tgt_src | input | IDW | Requesting core ID |
| tgt_dst | input | IDW | Target core ID |
| strap_in | input | STRAPW | Strap pin values |
| bus_rst_o | output | 1 | Peripheral and internal bus reset |
| cfg_rst_o | output | 1 | Configuration-space register reset (fundamental only) |
| core_rst_o | output | NCORE | Per-core reset |
| strap_lock_o | output | 1 | Strap capture is locked |
| strap_q_o | output | STRAPW | Latched strap values |

## Verification
The bus sequencer is tried with a lone register write, a lone watchdog pulse, both together, and a second request injected mid-pulse and on the last pulse cycle. Equal 16-cycle results show that requests merge and are neither extended nor replayed. Targeted requests are driven with a cross-core pair, with each core naming itself, with a held requester and with out-of-range IDs. These separate the valid-request check from target decoding and show that a self reset finishes. Hold bits are applied both alone and over a running pulse to show their priority. Strap inputs are changed after lock to show that no software reset samples them again.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
    typedef enum logic {
        BUS_IDLE,
        BUS_PULSE
    } bus_state_e;

    typedef enum logic [1:0] {
        CORE_RUN,
        CORE_PULSE,
        CORE_HELD
    } core_state_e;
endpackage

// File: rtl/swrst_strap_latch.sv
module swrst_strap_latch #(
    parameter int STRAPW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STRAPW-1:0] strap_in,
    output logic              lock_o,
    output logic [STRAPW-1:0] strap_q_o
);
    logic              lock_q;
    logic [STRAPW-1:0] strap_q;

    // Lock comes up at the first edge after the fundamental reset ends.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= 1'b1;
    end

    // Straps follow the pins until the lock is set, then freeze.
    always_ff @(posedge clk) begin
        if (!lock_q) strap_q <= strap_in;
    end

    assign lock_o    = lock_q;
    assign strap_q_o = strap_q;
endmodule

// File: rtl/swrst_bus_fsm.sv
module swrst_bus_fsm
    import swrst_pkg::*;
#(
    parameter int BUS_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);
    localparam int CW = $clog2(BUS_MIN + 1);
    localparam logic [CW-1:0] LAST = CW'(BUS_MIN - 1);

    bus_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (req_i) begin          // start
                    state_d = BUS_PULSE;
                    cnt_d   = '0;
                end
            end
            BUS_PULSE: begin
                // Requests seen here are absorbed into the running pulse.
                if (cnt_q == LAST) begin  // finish
                    state_d = BUS_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = BUS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        pulse_o = (state_q == BUS_PULSE);
    end
endmodule

// File: rtl/swrst_tgt_decode.sv
module swrst_tgt_decode #(
    parameter int NCORE = 2,
    parameter int IDW   = 2
) (
    input  logic             tgt_req,
    input  logic [IDW-1:0]   tgt_src,
    input  logic [IDW-1:0]   tgt_dst,
    input  logic [NCORE-1:0] core_busy_i,
    output logic [NCORE-1:0] hit_o
);
    logic src_ok;

    // The source must name an existing core that is currently running.
    always_comb begin
        src_ok = 1'b0;
        for (int i = 0; i < NCORE; i++) begin
            if (tgt_src == IDW'(i) && !core_busy_i[i]) src_ok = 1'b1;
        end
    end

    for (genvar g = 0; g < NCORE; g++) begin : g_hit
        assign hit_o[g] = tgt_req && src_ok && (tgt_dst == IDW'(g));
    end
endmodule

// File: rtl/swrst_core_fsm.sv
module swrst_core_fsm
    import swrst_pkg::*;
#(
    parameter int CORE_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic hit_i,
    output logic busy_o
);
    localparam int CW = $clog2(CORE_MIN + 1);
    localparam logic [CW-1:0] LAST = CW'(CORE_MIN - 1);

    core_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Cleared only by the fundamental reset, never by the core reset it drives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CORE_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CORE_RUN: begin
                if (hold_i) begin               // hold
                    state_d = CORE_HELD;
                end else if (hit_i) begin       // hit
                    state_d = CORE_PULSE;
                    cnt_d   = '0;
                end
            end
            CORE_PULSE: begin
                if (hold_i) begin               // hold
                    state_d = CORE_HELD;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin  // expire
                    state_d = CORE_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CORE_HELD: begin
                if (!hold_i) state_d = CORE_RUN;  // release
            end
            default: begin
                state_d = CORE_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        busy_o = (state_q != CORE_RUN);
    end
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl #(
    parameter int NCORE    = 2,
    parameter int IDW      = 2,
    parameter int STRAPW   = 4,
    parameter int BUS_MIN  = 16,
    parameter int CORE_MIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coord_wr,
    input  logic              wdt_expire,
    input  logic [NCORE-1:0]  hold_core,
    input  logic              tgt_req,
    input  logic [IDW-1:0]    tgt_src,
    input  logic [IDW-1:0]    tgt_dst,
    input  logic [STRAPW-1:0] strap_in,
    output logic              bus_rst_o,
    output logic              cfg_rst_o,
    output logic [NCORE-1:0]  core_rst_o,
    output logic              strap_lock_o,
    output logic [STRAPW-1:0] strap_q_o
);
    logic             lock;
    logic             bus_pulse;
    logic [NCORE-1:0] hit;
    logic [NCORE-1:0] busy;

    swrst_strap_latch #(.STRAPW(STRAPW)) u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_in  (strap_in),
        .lock_o    (lock),
        .strap_q_o (strap_q_o)
    );

    swrst_bus_fsm #(.BUS_MIN(BUS_MIN)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (coord_wr | wdt_expire),
        .pulse_o (bus_pulse)
    );

    swrst_tgt_decode #(.NCORE(NCORE), .IDW(IDW)) u_dec (
        .tgt_req     (tgt_req),
        .tgt_src     (tgt_src),
        .tgt_dst     (tgt_dst),
        .core_busy_i (core_rst_o),
        .hit_o       (hit)
    );

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        swrst_core_fsm #(.CORE_MIN(CORE_MIN)) u_core (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold_i (hold_core[g]),
            .hit_i  (hit[g]),
            .busy_o (busy[g])
        );
    end

    // Configuration space follows only the fundamental reset.
    assign cfg_rst_o    = ~lock;
    assign strap_lock_o = lock;
    assign bus_rst_o    = cfg_rst_o | bus_pulse;
    assign core_rst_o   = {NCORE{cfg_rst_o}} | busy;
endmodule

// File: rtl/swrst_ctrl_chk.sv
module swrst_ctrl_chk #(
    parameter int NCORE    = 2,
    parameter int IDW      = 2,
    parameter int STRAPW   = 4,
    parameter int BUS_MIN  = 16,
    parameter int CORE_MIN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCORE-1:0]  hold_core,
    input logic              tgt_req,
    input logic [IDW-1:0]    tgt_src,
    input logic [IDW-1:0]    tgt_dst,
    input logic              bus_rst_o,
    input logic              cfg_rst_o,
    input logic [NCORE-1:0]  core_rst_o,
    input logic              strap_lock_o,
    input logic [STRAPW-1:0] strap_q_o
);
    localparam int RW = $clog2(BUS_MIN + 2);

    logic [RW-1:0] run_q;
    logic          src_ok;

    // Length of the current software bus pulse, counted outside the design.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       run_q <= '0;
        else if (bus_rst_o && !cfg_rst_o) run_q <= run_q + 1'b1;
        else                              run_q <= '0;
    end

    always_comb begin
        src_ok = 1'b0;
        for (int i = 0; i < NCORE; i++) begin
            if (tgt_src == IDW'(i) && !core_rst_o[i]) src_ok = 1'b1;
        end
    end

    assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_o && !cfg_rst_o) |-> (run_q < RW'(BUS_MIN)));

    assert_pulse_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rst_o && !cfg_rst_o) && !bus_rst_o) |-> (run_q == RW'(BUS_MIN)));

    assert_strap_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strap_lock_o |=> (strap_lock_o && $stable(strap_q_o)));

    for (genvar g = 0; g < NCORE; g++) begin : g_core_chk
        assert_hold_enters_R6: assert property (@(posedge clk) disable iff (!rst_n)
            hold_core[g] |=> core_rst_o[g]);

        assert_target_hits_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tgt_req && src_ok && tgt_dst == IDW'(g)) |=> core_rst_o[g]);
    end
endmodule

bind swrst_ctrl swrst_ctrl_chk #(
    .NCORE(NCORE), .IDW(IDW), .STRAPW(STRAPW),
    .BUS_MIN(BUS_MIN), .CORE_MIN(CORE_MIN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_core    (hold_core),
    .tgt_req      (tgt_req),
    .tgt_src      (tgt_src),
    .tgt_dst      (tgt_dst),
    .bus_rst_o    (bus_rst_o),
    .cfg_rst_o    (cfg_rst_o),
    .core_rst_o   (core_rst_o),
    .strap_lock_o (strap_lock_o),
    .strap_q_o    (strap_q_o)
);

// File: tb/swrst_ctrl_tb.sv
`timescale 1ns/1ps
module swrst_ctrl_tb;
    localparam int NCORE    = 2;
    localparam int IDW      = 2;
    localparam int STRAPW   = 4;
    localparam int BUS_MIN  = 16;
    localparam int CORE_MIN = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              coord_wr = 1'b0;
    logic              wdt_expire = 1'b0;
    logic [NCORE-1:0]  hold_core = '0;
    logic              tgt_req = 1'b0;
    logic [IDW-1:0]    tgt_src = '0;
    logic [IDW-1:0]    tgt_dst = '0;
    logic [STRAPW-1:0] strap_in = 4'hA;
    logic              bus_rst_o;
    logic              cfg_rst_o;
    logic [NCORE-1:0]  core_rst_o;
    logic              strap_lock_o;
    logic [STRAPW-1:0] strap_q_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swrst_ctrl #(
        .NCORE(NCORE), .IDW(IDW), .STRAPW(STRAPW),
        .BUS_MIN(BUS_MIN), .CORE_MIN(CORE_MIN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .coord_wr(coord_wr), .wdt_expire(wdt_expire),
        .hold_core(hold_core), .tgt_req(tgt_req), .tgt_src(tgt_src), .tgt_dst(tgt_dst),
        .strap_in(strap_in), .bus_rst_o(bus_rst_o), .cfg_rst_o(cfg_rst_o),
        .core_rst_o(core_rst_o), .strap_lock_o(strap_lock_o), .strap_q_o(strap_q_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic count_bus(output int n);
        n = 0;
        while (bus_rst_o === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_core(input int idx, output int n);
        n = 0;
        while (core_rst_o[idx] === 1'b1 && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic fire_target(input int src, input int dst);
        @(negedge clk);
        tgt_req = 1'b1;
        tgt_src = IDW'(src);
        tgt_dst = IDW'(dst);
        @(negedge clk);
        tgt_req = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 cfg in reset", cfg_rst_o, 1);
        check("R1 bus in reset", bus_rst_o, 1);
        check("R1 cores in reset", core_rst_o, 2'b11);
        check("R1 lock in reset", strap_lock_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cfg released", cfg_rst_o, 0);
        check("R1 bus released", bus_rst_o, 0);
        check("R1 cores released", core_rst_o, 2'b00);
        check("R1 lock set", strap_lock_o, 1);
        check("R5 strap captured", strap_q_o, 4'hA);
    endtask

    task automatic t_bus(input logic cw, input logic wd, input string tag);
        int n;
        @(negedge clk);
        coord_wr = cw;
        wdt_expire = wd;
        @(negedge clk);
        coord_wr = 1'b0;
        wdt_expire = 1'b0;
        check("R4 cfg quiet in bus reset", cfg_rst_o, 0);
        check("R10 cores quiet in bus reset", core_rst_o, 2'b00);
        count_bus(n);
        check(tag, n, BUS_MIN);
        repeat (3) @(negedge clk);
        check("R3 no trailing pulse", bus_rst_o, 0);
    endtask

    task automatic t_bus_overlap;
        int n;
        @(negedge clk);
        coord_wr = 1'b1;
        @(negedge clk);
        coord_wr = 1'b0;
        n = 0;
        while (bus_rst_o === 1'b1 && n < 100) begin
            n++;
            wdt_expire = (n == 5);
            coord_wr = (n == BUS_MIN);
            @(negedge clk);
        end
        coord_wr = 1'b0;
        wdt_expire = 1'b0;
        check("R3 overlap pulse length", n, BUS_MIN);
        repeat (3) @(negedge clk);
        check("R3 last-cycle request absorbed", bus_rst_o, 0);
    endtask

    task automatic t_target(input int src, input int dst, input string tag);
        int n;
        fire_target(src, dst);
        check("R10 bus quiet in core reset", bus_rst_o, 0);
        check("R4 cfg quiet in core reset", cfg_rst_o, 0);
        check({tag, " other core"}, core_rst_o[1-dst], 0);
        count_core(dst, n);
        check(tag, n, CORE_MIN);
    endtask

    task automatic t_hold;
        @(negedge clk);
        hold_core[1] = 1'b1;
        @(negedge clk);
        check("R6 hold asserts", core_rst_o, 2'b10);
        repeat (30) @(negedge clk);
        check("R6 hold persists", core_rst_o, 2'b10);
        hold_core[1] = 1'b0;
        @(negedge clk);
        check("R6 release", core_rst_o, 2'b00);
    endtask

    task automatic t_ignored;
        @(negedge clk);
        hold_core[1] = 1'b1;
        fire_target(1, 0);
        repeat (4) @(negedge clk);
        check("R9 held source ignored", core_rst_o, 2'b10);
        hold_core[1] = 1'b0;
        @(negedge clk);
        fire_target(2, 1);
        check("R9 source id out of range", core_rst_o, 2'b00);
        repeat (3) @(negedge clk);
        check("R9 source id out of range later", core_rst_o, 2'b00);
        fire_target(0, 3);
        check("R9 target id out of range", core_rst_o, 2'b00);
        repeat (3) @(negedge clk);
        check("R9 target id out of range later", core_rst_o, 2'b00);
    endtask

    task automatic t_hold_in_pulse;
        fire_target(1, 0);
        repeat (2) @(negedge clk);
        hold_core[0] = 1'b1;
        repeat (15) @(negedge clk);
        check("R11 hold outlasts pulse", core_rst_o[0], 1);
        hold_core[0] = 1'b0;
        @(negedge clk);
        check("R11 release after hold", core_rst_o[0], 0);
    endtask

    task automatic t_strap_kept;
        check("R5 strap kept", strap_q_o, 4'hA);
        check("R5 lock kept", strap_lock_o, 1);
        check("R4 cfg never pulsed", cfg_rst_o, 0);
    endtask

    initial begin
        t_reset();
        strap_in = 4'h5;
        t_bus(1'b1, 1'b0, "R2 register write pulse length");
        t_bus(1'b0, 1'b1, "R2 watchdog pulse length");
        t_bus(1'b1, 1'b1, "R3 merged request pulse length");
        t_bus_overlap();
        t_target(1, 0, "R7 cross-core pulse length");
        t_target(0, 0, "R8 self reset core0");
        t_target(1, 1, "R8 self reset core1");
        t_hold();
        t_ignored();
        t_hold_in_pulse();
        strap_in = 4'h3;
        t_strap_kept();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule